// File: doc/BRIEF.md
# Hysteretic Solenoid Current Regulator

This block closes the current loop of a solenoid channel with a bang-bang law. Each cycle it compares a digitized current sample against two thresholds placed symmetrically around a 10-bit set point. When the current climbs past the upper threshold, the low-side gate command drops. When the current sinks below the lower threshold, the gate command rises again. The switching frequency and duty cycle are not programmed. They come from the load and the supply, because the controller only reacts to threshold crossings.

A 3-bit code selects the half-width of the band in DAC counts. After every gate transition, a blanking counter masks the comparison for a fixed number of cycles, so that switching transients cannot cause an immediate reversal. A set point of zero, or a low enable, parks the gate off. On each lower-threshold crossing the block emits a one-cycle strobe, which a dither sequencer can use to align its waveform.

Top module: `hyst_current_reg`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gate_on` and `low_cross` are 0.
- R2: When `enable` is low or `set_point` is 0 at a clock edge, `gate_on` is 0 after that edge, and the blanking count is cleared.
- R3: On the first edge at which `enable` is high with a nonzero `set_point` (after R2 held or after reset), `gate_on` goes to 1 and a blanking interval starts. No strobe is produced by this start.
- R4: With the gate on, outside blanking and with `sample_valid` high, `gate_on` goes to 0 at the edge where `sample` > `set_point` + half-band. A sample equal to that sum does not switch.
- R5: With the gate off, outside blanking and with `sample_valid` high, `gate_on` goes to 1 at the edge where `sample` < lower threshold. A sample equal to the lower threshold does not switch.
- R6: After every gate transition (R3, R4, R5), comparisons are ignored for BLANK_CYC clock edges. Switching can happen again at the edge BLANK_CYC+1 after the transition.
- R7: `hyst_code` values 0 to 7 select half-bands of 8, 15, 22, 29, 33, 37, 42 and 50 counts.
- R8: The lower threshold is `set_point` − half-band. When the half-band is not less than `set_point`, the lower threshold is 1. The upper threshold is computed one bit wider, so it never wraps.
- R9: A sample with `sample_valid` low causes no transition.
- R10: `low_cross` is high for exactly the one cycle after each R5 turn-on, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable |
| set_point | input | 10 | Average current command in DAC counts |
| hyst_code | input | 3 | Hysteresis band selector |
| sample | input | 10 | Measured current in DAC counts |
| sample_valid | input | 1 | Qualifies `sample` |
| gate_on | output | 1 | Low-side transistor command |
| low_cross | output | 1 | One-cycle lower-threshold crossing strobe |

## Verification
The hardest case to reach is a threshold crossing that lands exactly on the last cycle of blanking, or just after it. Free-running currents seldom line up with that cycle. The bench therefore drives samples open-loop and holds them above or below a threshold from the cycle of a transition onward, so the switch must happen at the first unmasked edge. It also pins a sample exactly on each threshold to separate strict from non-strict comparison. Closed-loop runs with a simple inductor-like plant then sweep every hysteresis code against the bench's reference model.

// File: rtl/hyst_current_reg.sv
module hyst_current_reg #(
  parameter int CW        = 10,
  parameter int BLANK_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] set_point,
  input  logic [2:0]    hyst_code,
  input  logic [CW-1:0] sample,
  input  logic          sample_valid,
  output logic          gate_on,
  output logic          low_cross
);

  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYC);

  logic [BW-1:0] blank_q;
  logic          run_q;
  logic [CW-1:0] half;
  logic [CW:0]   upper;
  logic [CW-1:0] lower;
  logic          active, open_win, hit_hi, hit_lo;

  always_comb begin
    case (hyst_code)
      3'd0:    half = CW'(8);
      3'd1:    half = CW'(15);
      3'd2:    half = CW'(22);
      3'd3:    half = CW'(29);
      3'd4:    half = CW'(33);
      3'd5:    half = CW'(37);
      3'd6:    half = CW'(42);
      default: half = CW'(50);
    endcase
  end

  assign active   = enable && (set_point != '0);
  assign upper    = {1'b0, set_point} + {1'b0, half};
  assign lower    = (set_point > half) ? (set_point - half) : CW'(1);
  assign open_win = run_q && (blank_q == '0) && sample_valid;
  assign hit_hi   = open_win &&  gate_on && ({1'b0, sample} > upper);
  assign hit_lo   = open_win && !gate_on && (sample < lower);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_on   <= 1'b0;
      low_cross <= 1'b0;
      blank_q   <= '0;
      run_q     <= 1'b0;
    end else begin
      low_cross <= 1'b0;
      if (!active) begin
        gate_on <= 1'b0;
        blank_q <= '0;
        run_q   <= 1'b0;
      end else if (!run_q) begin
        gate_on <= 1'b1;
        blank_q <= BLANK_LOAD;
        run_q   <= 1'b1;
      end else if (blank_q != '0) begin
        blank_q <= blank_q - 1'b1;
      end else if (hit_hi) begin
        gate_on <= 1'b0;
        blank_q <= BLANK_LOAD;
      end else if (hit_lo) begin
        gate_on   <= 1'b1;
        low_cross <= 1'b1;
        blank_q   <= BLANK_LOAD;
      end
    end
  end

  assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !gate_on && !low_cross);

  assert_blank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && run_q && blank_q != '0) |=> $stable(gate_on));

  assert_invalid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && run_q && !sample_valid) |=> $stable(gate_on));

  assert_strobe_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    low_cross |-> gate_on && !$past(gate_on));

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    low_cross |=> !low_cross);

  assert_off_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && $fell(gate_on) == 1'b0 && active && run_q && blank_q == '0 && sample_valid
     && ({1'b0, sample} > upper)) |=> !gate_on);

endmodule

// File: tb/hyst_current_reg_tb.sv
module hyst_current_reg_tb;
  localparam int BLANK = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [9:0] set_point = '0;
  logic [2:0] hyst_code = '0;
  logic [9:0] sample = '0;
  logic       sample_valid = 1'b0;
  logic       gate_on, low_cross;

  int checks = 0, errors = 0, strobes = 0;
  string cur_req = "R1";
  bit plant = 1'b0;

  int HB [8] = '{8, 15, 22, 29, 33, 37, 42, 50};
  bit m_gate = 0, m_strobe = 0, m_run = 0;
  int m_blank = 0;

  always #2 clk = ~clk;

  hyst_current_reg #(.CW(10), .BLANK_CYC(BLANK)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .set_point(set_point),
    .hyst_code(hyst_code), .sample(sample), .sample_valid(sample_valid),
    .gate_on(gate_on), .low_cross(low_cross));

  always @(posedge clk) begin
    int sp, hb, up, lo;
    sp = set_point; hb = HB[hyst_code];
    up = sp + hb;
    lo = (sp > hb) ? sp - hb : 1;
    m_strobe = 0;
    if (!rst_n) begin
      m_gate = 0; m_blank = 0; m_run = 0;
    end else if (!enable || sp == 0) begin
      m_gate = 0; m_blank = 0; m_run = 0;
    end else if (!m_run) begin
      m_gate = 1; m_blank = BLANK; m_run = 1;
    end else if (m_blank > 0) begin
      m_blank--;
    end else if (sample_valid) begin
      if (m_gate && int'(sample) > up) begin
        m_gate = 0; m_blank = BLANK;
      end else if (!m_gate && int'(sample) < lo) begin
        m_gate = 1; m_blank = BLANK; m_strobe = 1;
      end
    end
  end

  task automatic cmp();
    checks++;
    if (gate_on !== m_gate || low_cross !== m_strobe) begin
      errors++;
      $display("FAIL %s gate_on=%b expected %b low_cross=%b expected %b",
               cur_req, gate_on, m_gate, low_cross, m_strobe);
    end
    if (low_cross === 1'b1) strobes++;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp();
      if (plant) begin
        if (gate_on) sample = (int'(sample) + 7 > 1023) ? 10'd1023 : sample + 10'd7;
        else         sample = (sample < 10'd4) ? 10'd0 : sample - 10'd4;
      end
    end
  endtask

  task automatic expect_val(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    cyc(3);
    expect_val("R1 gate in reset", gate_on, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    expect_val("R1 strobe after reset", low_cross, 1'b0);

    // R3: start on with blanking; R4 exact-equal then above upper (400+29=429)
    cur_req = "R3";
    set_point = 10'd400; hyst_code = 3'd3; sample = 10'd429; sample_valid = 1'b1;
    enable = 1'b1;
    cyc(1);
    expect_val("R3 start on", gate_on, 1'b1);
    expect_val("R3 no strobe on start", low_cross, 1'b0);
    cur_req = "R4";
    cyc(10);
    expect_val("R4 equal keeps on", gate_on, 1'b1);
    sample = 10'd430;
    cyc(1);
    expect_val("R4 above turns off", gate_on, 1'b0);

    // R6: sample far below during blanking; must hold BLANK edges then switch
    cur_req = "R6";
    sample = 10'd0;
    cyc(BLANK);
    expect_val("R6 held during blanking", gate_on, 1'b0);
    cyc(1);
    expect_val("R6 switch after blanking", gate_on, 1'b1);
    expect_val("R10 strobe on low crossing", low_cross, 1'b1);
    cyc(1);
    expect_val("R10 strobe one cycle", low_cross, 1'b0);

    // R5: lower threshold 400-29=371, equal holds, below switches
    cur_req = "R5";
    sample = 10'd500;
    cyc(BLANK + 2);
    expect_val("R5 off after high", gate_on, 1'b0);
    sample = 10'd371;
    cyc(BLANK + 4);
    expect_val("R5 equal keeps off", gate_on, 1'b0);
    // R9: invalid samples ignored
    cur_req = "R9";
    sample_valid = 1'b0; sample = 10'd0;
    cyc(8);
    expect_val("R9 invalid ignored", gate_on, 1'b0);
    cur_req = "R5";
    sample_valid = 1'b1; sample = 10'd370;
    cyc(1);
    expect_val("R5 below turns on", gate_on, 1'b1);

    // R2: disable paths
    cur_req = "R2";
    enable = 1'b0;
    cyc(1);
    expect_val("R2 enable low off", gate_on, 1'b0);
    enable = 1'b1; set_point = 10'd0;
    cyc(3);
    expect_val("R2 zero command off", gate_on, 1'b0);

    // R8: band wider than set point -> lower threshold 1
    cur_req = "R8";
    set_point = 10'd20; hyst_code = 3'd7; sample = 10'd71;
    cyc(BLANK + 2);
    expect_val("R8 off above 70", gate_on, 1'b0);
    sample = 10'd1;
    cyc(BLANK + 3);
    expect_val("R8 one not below floor", gate_on, 1'b0);
    sample = 10'd0;
    cyc(1);
    expect_val("R8 zero turns on", gate_on, 1'b1);

    // R7: closed-loop sweep of every code
    cur_req = "R7";
    set_point = 10'd600; sample = 10'd500; plant = 1'b1;
    for (int c = 0; c < 8; c++) begin
      hyst_code = 3'(c);
      strobes = 0;
      cyc(400);
      checks++;
      if (strobes == 0) begin
        errors++;
        $display("FAIL R10 code %0d strobes actual=%0d expected>0", c, strobes);
      end
    end
    plant = 1'b0;

    cur_req = "R1";
    rst_n = 1'b0;
    cyc(2);
    expect_val("R1 reset mid-run", gate_on, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule